// File: doc/BRIEF.md
# Peripheral Clock Gating Controller

This block decides, cycle by cycle on an always-on clock, which of three peripheral clocks run (a serial UART, a timer and a serial bus interface) and whether the processor core clock runs. Software controls it through one five-bit control word that is written in a single cycle and can always be read back. Each peripheral has its own stop bit. A sleep-permit bit lets the core enter a stopped-clock state when it asks to.

The UART has an extra wake path. When the UART wake bit is set and software has stopped the UART clock, a toggle on the raw receive line restarts that clock so a character can come in. The restart clears only an internal gated flag. The stop bit that software sees stays at 1, and the UART clock stops again only when software writes the word. A UART interrupt brings a sleeping core back, but only if it is qualified: the UART must be set up to interrupt on a received character or framing error, and its interrupt must be enabled in the peripheral interrupt control. The clock-enable outputs drive clock-tree gating cells that sit outside this block.

Top module: `pclk_gate_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset the control word reads 0, all three peripheral clock enables are 1 and the core clock enable is 1.
- R2: A write of `ctl_wdata` is visible on `ctl_rdata` after the next rising edge. Each bit reads back at the bit position it was written to: bit 0 UART stop, bit 1 timer stop, bit 2 bus stop, bit 3 UART wake, bit 4 sleep permit.
- R3: Timer stop (bit 1) and bus stop (bit 2) work the same way. A value of 1 drives that clock enable to 0 and a value of 0 drives it to 1, starting on the edge that performs the write.
- R4: Writing UART stop (bit 0) as 1 drives `clk_en_uart` to 0 on the edge that performs the write, with no idle wait. Writing it as 0 drives the enable to 1.
- R5: The wake bit is 1 and the UART clock is stopped. A level change on `rxd` raises `clk_en_uart` on the third rising edge after the change (two synchronizer flops and one compare flop). Bit 0 of `ctl_rdata` stays 1.
- R6: While the wake bit is 0, a change on `rxd` leaves a stopped UART clock stopped.
- R7: After a receive-line restart, a new write with UART stop = 1 stops the UART clock again. A write on the same edge as a detected toggle takes priority over the toggle.
- R8: A `core_sleep_req` pulse drives `clk_en_core` to 0 on that edge only while the sleep-permit bit is 1. Otherwise the request is ignored.
- R9: A sleeping core wakes only when `uart_irq`, `uart_irq_rx_sel` and `uart_irq_en` are all 1. `clk_en_core` rises on that edge. If any one of the three is 0, the core stays asleep.
- R10: A UART clock restarted by the receive line stays enabled while the core enters and remains in sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write data |
| ctl_rdata | output | 5 | Control word read-back |
| rxd | input | 1 | Raw UART receive line, asynchronous |
| uart_irq | input | 1 | UART interrupt request |
| uart_irq_rx_sel | input | 1 | UART is set to interrupt on received character or framing error |
| uart_irq_en | input | 1 | UART interrupt enabled in the peripheral interrupt control |
| core_sleep_req | input | 1 | Core asks to stop its clock |
| clk_en_uart | output | 1 | UART clock enable |
| clk_en_timer | output | 1 | Timer clock enable |
| clk_en_bus | output | 1 | Serial bus interface clock enable |
| clk_en_core | output | 1 | Core clock enable |

## Verification
The control word is stepped through a table of values. The table includes all-zero, single stop bits, all stops together and words that change only the wake or sleep bits. This shows that each stop bit drives only its own clock enable and that the upper bits leave the enables alone. The receive line is then toggled in both directions, once with wake off and once with wake on. Sampling just before and just after the third edge pins down the restart latency. A rewrite after the restart confirms that software can stop the clock again. For the core, a sleep request is given with and without the permit. Wake is tried with each of the three interrupt qualifiers missing in turn and then with all three present. This separates a qualified wake from a partial one.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int CTL_W = 5;

  // field order sets read-back bit positions: uart_off is bit 0
  typedef struct packed {
    logic sleep_en;
    logic uart_wake;
    logic bus_off;
    logic timer_off;
    logic uart_off;
  } ctl_t;

  localparam ctl_t CTL_RESET = '0;
endpackage

// File: rtl/pclk_rx_edge.sv
module pclk_rx_edge #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd,
  output logic rx_toggle
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= IDLE;
          else     chain_q[i] <= rxd;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= IDLE;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  // synchronized sample differs from the one before it
  assign rx_toggle = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];
endmodule

// File: rtl/pclk_ctl_regs.sv
module pclk_ctl_regs
  import pclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl
);
  always_ff @(posedge clk) begin
    if (rst)     ctl <= CTL_RESET;
    else if (wr) ctl <= ctl_t'(wdata);
  end
endmodule

// File: rtl/pclk_uart_gate.sv
module pclk_uart_gate (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wr_off,
  input  logic wake_en,
  input  logic rx_toggle,
  output logic clk_en
);
  logic gated_q;

  always_ff @(posedge clk) begin
    if (rst)                                gated_q <= 1'b0;
    else if (wr)                            gated_q <= wr_off;
    else if (gated_q && wake_en && rx_toggle) gated_q <= 1'b0;
  end

  assign clk_en = ~gated_q;
endmodule

// File: rtl/pclk_core_sleep.sv
module pclk_core_sleep (
  input  logic clk,
  input  logic rst,
  input  logic sleep_en,
  input  logic sleep_req,
  input  logic wake_req,
  output logic clk_en
);
  logic asleep_q;

  always_ff @(posedge clk) begin
    if (rst)                        asleep_q <= 1'b0;
    else if (asleep_q)              asleep_q <= ~wake_req;
    else if (sleep_req && sleep_en) asleep_q <= 1'b1;
  end

  assign clk_en = ~asleep_q;
endmodule

// File: rtl/pclk_gate_ctrl.sv
module pclk_gate_ctrl
  import pclk_pkg::*;
#(
  parameter int RX_SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             rxd,
  input  logic             uart_irq,
  input  logic             uart_irq_rx_sel,
  input  logic             uart_irq_en,
  input  logic             core_sleep_req,
  output logic             clk_en_uart,
  output logic             clk_en_timer,
  output logic             clk_en_bus,
  output logic             clk_en_core
);
  ctl_t ctl;
  logic rx_toggle;
  logic wake_req;
  ctl_t wr_fields;

  assign wr_fields = ctl_t'(ctl_wdata);

  pclk_ctl_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .ctl   (ctl)
  );

  pclk_rx_edge #(.STAGES(RX_SYNC_STAGES), .IDLE(1'b1)) u_rx_edge (
    .clk       (clk),
    .rst       (rst),
    .rxd       (rxd),
    .rx_toggle (rx_toggle)
  );

  pclk_uart_gate u_uart_gate (
    .clk       (clk),
    .rst       (rst),
    .wr        (ctl_wr),
    .wr_off    (wr_fields.uart_off),
    .wake_en   (ctl.uart_wake),
    .rx_toggle (rx_toggle),
    .clk_en    (clk_en_uart)
  );

  assign wake_req = uart_irq & uart_irq_rx_sel & uart_irq_en;

  pclk_core_sleep u_core_sleep (
    .clk       (clk),
    .rst       (rst),
    .sleep_en  (ctl.sleep_en),
    .sleep_req (core_sleep_req),
    .wake_req  (wake_req),
    .clk_en    (clk_en_core)
  );

  assign ctl_rdata    = ctl;
  assign clk_en_timer = ~ctl.timer_off;
  assign clk_en_bus   = ~ctl.bus_off;
endmodule

// File: rtl/pclk_gate_ctrl_chk.sv
module pclk_gate_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic [4:0] ctl_wdata,
  input logic [4:0] ctl_rdata,
  input logic       uart_irq,
  input logic       uart_irq_rx_sel,
  input logic       uart_irq_en,
  input logic       clk_en_uart,
  input logic       clk_en_timer,
  input logic       clk_en_bus,
  input logic       clk_en_core
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ctl_rdata == 5'd0 && clk_en_uart && clk_en_timer && clk_en_bus && clk_en_core));

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> ctl_rdata == $past(ctl_wdata));

  // R3
  timer_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (clk_en_timer == !$past(ctl_wdata[1]) && clk_en_bus == !$past(ctl_wdata[2])));

  // R4
  uart_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> clk_en_uart == !$past(ctl_wdata[0]));

  // R6
  uart_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && !ctl_rdata[3] && !clk_en_uart) |=> !clk_en_uart);

  // R8
  sleep_permit_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_rdata[4] && clk_en_core) |=> clk_en_core);

  // R9
  core_stays_asleep_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_core && !(uart_irq && uart_irq_rx_sel && uart_irq_en)) |=> !clk_en_core);

  // R9
  core_wakes_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_core && uart_irq && uart_irq_rx_sel && uart_irq_en) |=> clk_en_core);
endmodule

bind pclk_gate_ctrl pclk_gate_ctrl_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .ctl_wr          (ctl_wr),
  .ctl_wdata       (ctl_wdata),
  .ctl_rdata       (ctl_rdata),
  .uart_irq        (uart_irq),
  .uart_irq_rx_sel (uart_irq_rx_sel),
  .uart_irq_en     (uart_irq_en),
  .clk_en_uart     (clk_en_uart),
  .clk_en_timer    (clk_en_timer),
  .clk_en_bus      (clk_en_bus),
  .clk_en_core     (clk_en_core)
);

// File: tb/pclk_gate_ctrl_tb.sv
module pclk_gate_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic [4:0] ctl_rdata;
  logic       rxd = 1'b1;
  logic       uart_irq = 1'b0;
  logic       uart_irq_rx_sel = 1'b0;
  logic       uart_irq_en = 1'b0;
  logic       core_sleep_req = 1'b0;
  logic       clk_en_uart, clk_en_timer, clk_en_bus, clk_en_core;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pclk_gate_ctrl u_dut (
    .clk             (clk),
    .rst             (rst),
    .ctl_wr          (ctl_wr),
    .ctl_wdata       (ctl_wdata),
    .ctl_rdata       (ctl_rdata),
    .rxd             (rxd),
    .uart_irq        (uart_irq),
    .uart_irq_rx_sel (uart_irq_rx_sel),
    .uart_irq_en     (uart_irq_en),
    .core_sleep_req  (core_sleep_req),
    .clk_en_uart     (clk_en_uart),
    .clk_en_timer    (clk_en_timer),
    .clk_en_bus      (clk_en_bus),
    .clk_en_core     (clk_en_core)
  );

  // vector: {write data, expected {bus,timer,uart} enables}
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    {5'b00000, 3'b111},
    {5'b00001, 3'b110},
    {5'b00010, 3'b101},
    {5'b00100, 3'b011},
    {5'b00111, 3'b000},
    {5'b01000, 3'b111},
    {5'b10000, 3'b111},
    {5'b11010, 3'b101}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [4:0] d);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic set_rxd(input logic v);
    @(negedge clk);
    rxd = v;
  endtask

  task automatic sleep_pulse();
    @(negedge clk);
    core_sleep_req = 1'b1;
    @(negedge clk);
    core_sleep_req = 1'b0;
  endtask

  task automatic irq_pulse(input logic a, input logic b, input logic c);
    @(negedge clk);
    uart_irq = a; uart_irq_rx_sel = b; uart_irq_en = c;
    @(negedge clk);
    uart_irq = 1'b0; uart_irq_rx_sel = 1'b0; uart_irq_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", ctl_rdata, 5'd0);
    check("R1 enables", {clk_en_core, clk_en_bus, clk_en_timer, clk_en_uart}, 4'b1111);

    // R2 R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      write_ctl(VEC[i][7:3]);
      check("R2 readback", ctl_rdata, VEC[i][7:3]);
      check("R3/R4 enables", {clk_en_bus, clk_en_timer, clk_en_uart}, VEC[i][2:0]);
    end

    // R6: wake off, stopped UART ignores rxd
    write_ctl(5'b00001);
    set_rxd(1'b0);
    repeat (5) @(negedge clk);
    check("R6 uart stays off", clk_en_uart, 1'b0);
    set_rxd(1'b1);
    repeat (5) @(negedge clk);
    check("R6 uart stays off", clk_en_uart, 1'b0);

    // R5: wake on, falling rxd restarts on third edge
    write_ctl(5'b01001);
    set_rxd(1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R5 not yet", clk_en_uart, 1'b0);
    @(negedge clk);
    check("R5 restarted", clk_en_uart, 1'b1);
    check("R5 stop bit kept", ctl_rdata[0], 1'b1);

    // R7: rewrite stops again, rising rxd restarts again
    write_ctl(5'b01001);
    check("R7 re-stopped", clk_en_uart, 1'b0);
    set_rxd(1'b1);
    repeat (3) @(negedge clk);
    check("R5 rising restart", clk_en_uart, 1'b1);

    // R8: sleep without permit is ignored
    write_ctl(5'b00000);
    sleep_pulse();
    check("R8 no permit", clk_en_core, 1'b1);

    // R10: restart, then core sleeps; UART stays clocked
    write_ctl(5'b11001);
    check("R4 uart off", clk_en_uart, 1'b0);
    set_rxd(1'b0);
    repeat (3) @(negedge clk);
    check("R10 uart on", clk_en_uart, 1'b1);
    sleep_pulse();
    check("R8 asleep", clk_en_core, 1'b0);
    repeat (5) @(negedge clk);
    check("R10 uart on while asleep", clk_en_uart, 1'b1);

    // R9: partial qualifiers do not wake
    irq_pulse(1'b0, 1'b1, 1'b1);
    check("R9 no irq", clk_en_core, 1'b0);
    irq_pulse(1'b1, 1'b0, 1'b1);
    check("R9 no rx sel", clk_en_core, 1'b0);
    irq_pulse(1'b1, 1'b1, 1'b0);
    check("R9 no enable", clk_en_core, 1'b0);
    irq_pulse(1'b1, 1'b1, 1'b1);
    check("R9 woke", clk_en_core, 1'b1);

    // R1 reset again from a busy state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 rdata after reset", ctl_rdata, 5'd0);
    check("R1 enables after reset", {clk_en_core, clk_en_bus, clk_en_timer, clk_en_uart}, 4'b1111);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule